// File: doc/BRIEF.md
# Serial Bus Loopback and Idle-Qualification Gate

This block sits between the data-link controller core of a J1850-style serial bus and the pins of the physical layer. A loopback control bit chooses where the core's receive digital filter gets its input. With the bit set, the filter reads the core's own transmitter output, so software can tell whether a fault lies in the digital logic or out on the wire. While loopback is on, the transmit pin is held at the passive (low) level.

A second control bit holds the link state machine in reset. The falling edge of that bit sends a single reset pulse to the core. After that pulse, after power-on reset, and after loopback is switched off, the block blocks reception and transmission until the filtered bus input has stayed passive for long enough. Reception reopens after an end-of-frame idle time. Transmission reopens after a longer inter-frame idle time. Both times are parameters counted in clock cycles, and the inter-frame time must be larger than the end-of-frame time.

Top module: `bus_loop_gate`

## Requirements
- R1: With `ctl_loopback` = 1, `core_filter_in` equals `core_tx_out` in the same cycle.
- R2: With `ctl_loopback` = 1, `pin_tx` is 0 whatever `core_tx_out` is.
- R3: With `ctl_loopback` = 0, `core_filter_in` equals `pin_rx` and `pin_tx` equals `core_tx_out`, both in the same cycle.
- R4: When a clock edge sees `ctl_sm_reset` at 0 after it was 1 at the previous edge, `core_sm_rst` is 1 for exactly the next cycle. Setting the bit produces no pulse.
- R5: While `rst` or `ctl_sm_reset` is 1, `core_rx_en` and `core_tx_en` are 0.
- R6: Take the edge of a restart (reset, or the release of `ctl_sm_reset`). If the filter input is 0 (passive) at each of the next EOF_CYC edges, `core_rx_en` is 1 after the EOF_CYC-th of those edges and not before.
- R7: Under the same conditions, `core_tx_en` is 1 after the IFS_CYC-th idle edge and not before.
- R8: An edge that sees `ctl_loopback` fall from 1 to 0 clears both enables and restarts the qualification of R6 and R7.
- R9: A 1 (active) on the filter input at an edge resets the idle count to zero, so a new full run of idle edges is needed. Enables that were already granted stay at 1.
- R10: If `ctl_loopback` differs from its value at the previous edge while `tx_busy` is 1, `proto_err` is 1 for the following cycle. Otherwise it is 0.
- R11: The idle count saturates at IFS_CYC, so granted enables stay at 1 through an idle period of any length.
- R12: `core_tx_en` is never 1 while `core_rx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sm_reset | input | 1 | Control bit: hold the link state machine in reset |
| ctl_loopback | input | 1 | Control bit: digital loopback |
| tx_busy | input | 1 | The core has a transmission in progress |
| pin_rx | input | 1 | Receive pin from the physical layer |
| pin_tx | output | 1 | Transmit pin to the physical layer |
| core_tx_out | input | 1 | Core transmitter output |
| core_filter_in | output | 1 | Core receive digital filter input |
| core_sm_rst | output | 1 | One-cycle reset pulse to the link state machine |
| core_rx_en | output | 1 | Reception allowed |
| core_tx_en | output | 1 | Transmission allowed |
| proto_err | output | 1 | Loopback changed during a transmission |

## Verification
The pin and filter paths are combinational. The bench changes their inputs one nanosecond after an edge and reads the outputs before the next edge. `core_sm_rst` and `proto_err` appear one edge after the edge that sees the control change. Each enable rises after exactly its threshold number of idle edges, counted from the restart edge. The bench checks every enable one edge before its threshold, where it must still be 0, and again at the threshold, where it must be 1. So an error of one cycle in either direction shows up.

// File: rtl/bus_gate_pkg.sv
`timescale 1ns/1ps
package bus_gate_pkg;

    // Level of an undriven (passive) bus
    localparam logic BUS_PASSIVE = 1'b0;

    typedef struct packed {
        logic sm_reset;
        logic loopback;
    } gate_ctl_t;

    typedef struct packed {
        logic restart;
        logic sm_pulse;
        logic lb_err;
    } gate_evt_t;

    typedef struct packed {
        logic rx_ok;
        logic tx_ok;
    } qual_state_t;

    function automatic int unsigned sat_next(input int unsigned cur,
                                             input int unsigned lim);
        return (cur >= lim) ? lim : cur + 1;
    endfunction

endpackage

// File: rtl/blg_path_mux.sv
`timescale 1ns/1ps
module blg_path_mux
    import bus_gate_pkg::*;
(
    input  logic loopback,
    input  logic pin_rx,
    input  logic tx_out,
    output logic filter_in,
    output logic pin_tx
);

    always_comb begin
        if (loopback) begin
            filter_in = tx_out;
            pin_tx    = BUS_PASSIVE;
        end else begin
            filter_in = pin_rx;
            pin_tx    = tx_out;
        end
    end

endmodule

// File: rtl/blg_ctl_edges.sv
`timescale 1ns/1ps
module blg_ctl_edges
    import bus_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_ctl_t ctl,
    input  logic      tx_busy,
    output gate_evt_t evt
);

    gate_ctl_t ctl_q;
    logic      pulse_q;
    logic      err_q;
    logic      smr_fall;
    logic      lb_fall;
    logic      lb_change;

    always_comb begin
        smr_fall  = ctl_q.sm_reset & ~ctl.sm_reset;
        lb_fall   = ctl_q.loopback & ~ctl.loopback;
        lb_change = ctl_q.loopback ^ ctl.loopback;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            pulse_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            ctl_q   <= ctl;
            pulse_q <= smr_fall;
            err_q   <= lb_change & tx_busy;
        end
    end

    always_comb begin
        evt.restart  = rst | ctl.sm_reset | smr_fall | lb_fall;
        evt.sm_pulse = pulse_q;
        evt.lb_err   = err_q;
    end

    // R4
    sm_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R10
    lb_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(tx_busy));

endmodule

// File: rtl/blg_idle_qual.sv
`timescale 1ns/1ps
module blg_idle_qual
    import bus_gate_pkg::*;
#(
    parameter int unsigned EOF_CYC = 4000,
    parameter int unsigned IFS_CYC = 6000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic filt,
    output logic rx_en,
    output logic tx_en
);

    localparam int unsigned CNT_W = $clog2(IFS_CYC + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    qual_state_t      st_q, st_d;
    logic             idle;

    assign idle = (filt == BUS_PASSIVE);

    always_comb begin
        cnt_d = cnt_q;
        st_d  = st_q;
        if (restart) begin
            cnt_d = '0;
            st_d  = '0;
        end else if (!idle) begin
            cnt_d = '0;
        end else begin
            cnt_d = CNT_W'(sat_next(32'(cnt_q), IFS_CYC));
            if (32'(cnt_d) >= EOF_CYC) st_d.rx_ok = 1'b1;
            if (32'(cnt_d) >= IFS_CYC) st_d.tx_ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            st_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            st_q  <= st_d;
        end
    end

    assign rx_en = st_q.rx_ok;
    assign tx_en = st_q.tx_ok;

    // R11
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) <= IFS_CYC);

    // R12
    tx_needs_rx_chk: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> rx_en);

    // R5
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!rx_en && !tx_en));

    // R9
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && rx_en) |=> rx_en);

    // R6
    rx_rise_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_en) |-> $past(idle));

endmodule

// File: rtl/bus_loop_gate.sv
`timescale 1ns/1ps
module bus_loop_gate
    import bus_gate_pkg::*;
#(
    parameter int unsigned EOF_CYC = 4000,
    parameter int unsigned IFS_CYC = 6000
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_sm_reset,
    input  logic ctl_loopback,
    input  logic tx_busy,
    input  logic pin_rx,
    output logic pin_tx,
    input  logic core_tx_out,
    output logic core_filter_in,
    output logic core_sm_rst,
    output logic core_rx_en,
    output logic core_tx_en,
    output logic proto_err
);

    gate_ctl_t ctl;
    gate_evt_t evt;

    assign ctl.sm_reset = ctl_sm_reset;
    assign ctl.loopback = ctl_loopback;

    blg_path_mux u_mux (
        .loopback  (ctl_loopback),
        .pin_rx    (pin_rx),
        .tx_out    (core_tx_out),
        .filter_in (core_filter_in),
        .pin_tx    (pin_tx)
    );

    blg_ctl_edges u_edges (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .tx_busy (tx_busy),
        .evt     (evt)
    );

    blg_idle_qual #(
        .EOF_CYC (EOF_CYC),
        .IFS_CYC (IFS_CYC)
    ) u_qual (
        .clk     (clk),
        .rst     (rst),
        .restart (evt.restart),
        .filt    (core_filter_in),
        .rx_en   (core_rx_en),
        .tx_en   (core_tx_en)
    );

    assign core_sm_rst = evt.sm_pulse;
    assign proto_err   = evt.lb_err;

    // R2
    lb_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_loopback && $stable(ctl_loopback)) |-> (pin_tx == BUS_PASSIVE));

endmodule

// File: tb/bus_loop_gate_bench.sv
`timescale 1ns/1ps
module bus_loop_gate_bench;

    localparam int EOF_C = 12;
    localparam int IFS_C = 20;

    // {loopback, pin_rx, core_tx_out, expected filter_in, expected pin_tx}
    localparam logic [4:0] VEC [8] = '{
        5'b00000, 5'b00101, 5'b01010, 5'b01111,
        5'b10000, 5'b10110, 5'b11000, 5'b11110
    };

    logic clk = 1'b0;
    logic rst, ctl_sm_reset, ctl_loopback, tx_busy, pin_rx, core_tx_out;
    logic pin_tx, core_filter_in, core_sm_rst, core_rx_en, core_tx_en, proto_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_loop_gate #(.EOF_CYC(EOF_C), .IFS_CYC(IFS_C)) u_bus_loop_gate (
        .clk(clk), .rst(rst), .ctl_sm_reset(ctl_sm_reset),
        .ctl_loopback(ctl_loopback), .tx_busy(tx_busy), .pin_rx(pin_rx),
        .pin_tx(pin_tx), .core_tx_out(core_tx_out),
        .core_filter_in(core_filter_in), .core_sm_rst(core_sm_rst),
        .core_rx_en(core_rx_en), .core_tx_en(core_tx_en), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; ctl_sm_reset = 1'b0; ctl_loopback = 1'b0;
        tx_busy = 1'b0; pin_rx = 1'b0; core_tx_out = 1'b0;
        step(3);
        chk("R5 reset rx_en", core_rx_en, 1'b0);
        chk("R5 reset tx_en", core_tx_en, 1'b0);
        chk("R4 reset no pulse", core_sm_rst, 1'b0);
        rst = 1'b0;

        // R1 R2 R3: path table
        foreach (VEC[i]) begin
            ctl_loopback = VEC[i][4];
            pin_rx       = VEC[i][3];
            core_tx_out  = VEC[i][2];
            #1;
            chk("R1/R3 filter_in", core_filter_in, VEC[i][1]);
            chk("R2/R3 pin_tx", pin_tx, VEC[i][0]);
            step(1);
            chk("R10 no err when idle tx", proto_err, 1'b0);
        end

        // Restart from reset
        ctl_loopback = 1'b0; pin_rx = 1'b0; core_tx_out = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(EOF_C - 1);
        chk("R6 rx_en before EOF", core_rx_en, 1'b0);
        step(1);
        chk("R6 rx_en at EOF", core_rx_en, 1'b1);
        chk("R7 tx_en at EOF", core_tx_en, 1'b0);
        step(IFS_C - EOF_C - 1);
        chk("R7 tx_en before IFS", core_tx_en, 1'b0);
        chk("R12 rx held", core_rx_en, 1'b1);
        step(1);
        chk("R7 tx_en at IFS", core_tx_en, 1'b1);
        step(100);
        chk("R11 rx_en long idle", core_rx_en, 1'b1);
        chk("R11 tx_en long idle", core_tx_en, 1'b1);

        // R9: activity keeps granted enables
        pin_rx = 1'b1;
        step(3);
        chk("R9 rx kept on activity", core_rx_en, 1'b1);
        chk("R9 tx kept on activity", core_tx_en, 1'b1);
        pin_rx = 1'b0;

        // R4 R5: state machine reset bit
        ctl_sm_reset = 1'b1;
        step(1);
        chk("R5 sm reset rx_en", core_rx_en, 1'b0);
        chk("R5 sm reset tx_en", core_tx_en, 1'b0);
        chk("R4 no pulse on set", core_sm_rst, 1'b0);
        step(3);
        ctl_sm_reset = 1'b0;
        step(1);
        chk("R4 pulse after clear", core_sm_rst, 1'b1);
        step(1);
        chk("R4 pulse one cycle", core_sm_rst, 1'b0);
        step(EOF_C - 3);
        chk("R9 rx_en before burst", core_rx_en, 1'b0);
        pin_rx = 1'b1;
        step(1);
        pin_rx = 1'b0;
        step(EOF_C - 1);
        chk("R9 count restarted", core_rx_en, 1'b0);
        step(1);
        chk("R9 rx_en after full idle", core_rx_en, 1'b1);

        // R8: loopback on keeps qualifying, off restarts
        ctl_loopback = 1'b1;
        step(IFS_C);
        chk("R8 tx_en in loopback", core_tx_en, 1'b1);
        ctl_loopback = 1'b0;
        step(1);
        chk("R8 rx_en cleared", core_rx_en, 1'b0);
        chk("R8 tx_en cleared", core_tx_en, 1'b0);
        step(EOF_C - 1);
        chk("R8 rx_en before EOF", core_rx_en, 1'b0);
        step(1);
        chk("R8 rx_en at EOF", core_rx_en, 1'b1);

        // R10: loopback change during transmission
        tx_busy = 1'b1;
        ctl_loopback = 1'b1;
        step(1);
        chk("R10 err pulse", proto_err, 1'b1);
        step(1);
        chk("R10 err one cycle", proto_err, 1'b0);
        tx_busy = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule